// File: doc/BRIEF.md
# SD Card Command Line Engine

This block runs one SD card command at a time over the single-bit CMD line. Software loads a 32-bit argument, then writes a 16-bit command word with its start flag set. The engine then shifts out a 48-bit command frame protected by CRC7. After that it either collects a 48-bit or a 136-bit response, waits a fixed pause when no response is expected, or gives up when the card stays silent for too long. It can also hold the command open until the card releases its busy signal on DAT0.

Completion is reported by the engine clearing the start flag in the command word. A separate fail flag in the same word marks an unsuccessful command. Cause bits in a host status register tell a timeout from a CRC error, and a third status bit marks the end of busy. Card-side timing advances only on cycles where the card clock enable is high, so the engine can sit behind any external clock divider. Register access is a plain write strobe with a 2-bit address, and every register can be read back through dedicated output ports.

Top module: `sdc_cmd_engine`

## Requirements
- R1: After reset the command word, the host status and all four response words read as zero, and the CMD line is not driven (`cmd_oe_o` low, `cmd_out_o` high).
- R2: A write to address 0 with bit 15 set, while bit 15 of the command word is clear, starts a command. The engine drives this frame on CMD, most significant bit first and one bit per enabled card clock: start bit 0, direction bit 1, the index from bits 5:0, the argument from address 1, the CRC7 (polynomial x^7+x^3+1) of those first 40 bits, and an end bit 1.
- R3: Bit 15 of the command word stays set until the command finishes and is cleared on completion. Any write to address 0 while bit 15 is set leaves the command word unchanged.
- R4: When bit 10 (no response) is set, the command completes on the eighth enabled card clock after the clock that shifted out the end bit, and it reports no fail and no error.
- R5: With bits 9 and 10 clear, a response starts at the first enabled card clock on which CMD is sampled low, and it is 48 bits long. Its 32 bits between the 8-bit header and the CRC go to response word 0. If its CRC7 over the first 40 bits differs from its bits 7:1, status bit 4 and command bit 14 are set.
- R6: With bit 9 set, the response is 136 bits long. Its last 128 bits are placed with bits 31:0 in response word 0 up to bits 127:96 in response word 3, and no CRC check is applied.
- R7: While the engine waits for a response start, the timeout value written at address 2 is counted down by one per enabled card clock on which CMD is high. With a value of T, the command ends on the T-th such clock, and status bit 6 and command bit 14 are set.
- R8: With bit 11 (busy wait) set and a clean response, the command stays open after the response until DAT0 is sampled high on an enabled card clock. It then completes and sets status bit 10, with no fail.
- R9: Writing address 3 clears exactly those of status bits 10, 6 and 4 that are 1 in the written data, and leaves the others unchanged.
- R10: The CMD line is driven only while bit 15 of the command word is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_ce_i | input | 1 | Card clock enable, one card clock per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 command, 1 argument, 2 timeout, 3 status |
| wr_data_i | input | 32 | Register write data |
| cmd_reg_o | output | 16 | Command word readback |
| arg_reg_o | output | 32 | Argument readback |
| host_status_o | output | 11 | Host status: bit 10 busy end, bit 6 timeout, bit 4 CRC error |
| rsp_w0_o | output | 32 | Response word 0 |
| rsp_w1_o | output | 32 | Response word 1 |
| rsp_w2_o | output | 32 | Response word 2 |
| rsp_w3_o | output | 32 | Response word 3 |
| cmd_out_o | output | 1 | CMD line output value |
| cmd_oe_o | output | 1 | CMD line output enable |
| cmd_in_i | input | 1 | CMD line sampled from the card |
| dat0_i | input | 1 | DAT0 line sampled from the card |

## Verification
The assertions check on every cycle that a driven frame opens with a 0 and closes with a 1. They also check that the line is driven only while a command is open, that a completion strobe always clears the start flag, that a raised fail flag always has a recorded cause, and that the busy-end bit rises only together with completion. Only the bench's card model can show the rest: the exact frame content and CRC, where response bits land in the four words, the exact eight-clock pause and the timeout count, that long responses escape the CRC check, that a write during an open command is ignored, and that status bits clear one by one.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TX, ST_WAIT, ST_RX, ST_EVAL, ST_GAP, ST_BUSY
  } sdc_state_e;

  localparam int CMD_FRAME_W  = 48;
  localparam int LONG_FRAME_W = 136;
  localparam int HEAD_W       = 40;

  // command word bit positions (software decodes these)
  localparam int B_LONG  = 9;
  localparam int B_NORSP = 10;
  localparam int B_BUSYW = 11;
  localparam int B_FAIL  = 14;
  localparam int B_NEW   = 15;

  // host status bit positions
  localparam int S_CRC  = 4;
  localparam int S_TMO  = 6;
  localparam int S_BUSY = 10;

  // CRC7, polynomial x^7 + x^3 + 1, message MSB first
  function automatic logic [6:0] crc7_40(input logic [HEAD_W-1:0] d);
    logic [6:0] c;
    logic       fb;
    c = '0;
    for (int i = HEAD_W - 1; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

endpackage

// File: rtl/sdc_tx_shift.sv
module sdc_tx_shift #(
  parameter int FRAME_W = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               line_o
);

  logic [FRAME_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load_i)       sr_d = frame_i;
    else if (shift_i) sr_d = {sr_q[FRAME_W-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '1;
    else        sr_q <= sr_d;
  end

  assign line_o = sr_q[FRAME_W-1];

endmodule

// File: rtl/sdc_rx_shift.sv
module sdc_rx_shift #(
  parameter int FRAME_W = 136
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               shift_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] frame_o
);

  logic [FRAME_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (clr_i)        sr_d = '0;
    else if (shift_i) sr_d = {sr_q[FRAME_W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign frame_o = sr_q;

endmodule

// File: rtl/sdc_cmd_fsm.sv
module sdc_cmd_fsm
  import sdc_pkg::*;
#(
  parameter int TOUT_W   = 32,
  parameter int GAP_CLKS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce_i,
  input  logic                   go_i,
  input  logic                   long_i,
  input  logic                   no_rsp_i,
  input  logic                   busy_wait_i,
  input  logic [TOUT_W-1:0]      tout_i,
  input  logic                   cmd_in_i,
  input  logic                   dat0_i,
  input  logic [CMD_FRAME_W-1:0] rsp_short_i,
  output logic                   tx_load_o,
  output logic                   tx_shift_o,
  output logic                   rx_shift_o,
  output logic                   cmd_oe_o,
  output logic                   done_o,
  output logic                   tmo_o,
  output logic                   crc_err_o,
  output logic                   busy_end_o
);

  localparam int CNT_MAX = (GAP_CLKS > LONG_FRAME_W) ? GAP_CLKS : LONG_FRAME_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] TX_LAST    = CNT_W'(CMD_FRAME_W - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(CMD_FRAME_W - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_FRAME_W - 1);
  localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(GAP_CLKS - 1);
  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);
  localparam logic [TOUT_W-1:0] TOUT_ONE  = TOUT_W'(1);

  sdc_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [TOUT_W-1:0] tcnt_q, tcnt_d;
  logic              crc_bad;

  assign crc_bad  = rsp_short_i[7:1] != crc7_40(rsp_short_i[CMD_FRAME_W-1:8]);
  assign cmd_oe_o = (st_q == ST_TX);

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    tcnt_d     = tcnt_q;
    tx_load_o  = 1'b0;
    tx_shift_o = 1'b0;
    rx_shift_o = 1'b0;
    done_o     = 1'b0;
    tmo_o      = 1'b0;
    crc_err_o  = 1'b0;
    busy_end_o = 1'b0;
    case (st_q)
      ST_IDLE: if (go_i) begin
        st_d      = ST_TX;
        cnt_d     = '0;
        tx_load_o = 1'b1;
      end
      ST_TX: if (ce_i) begin
        tx_shift_o = 1'b1;
        if (cnt_q == TX_LAST) begin
          cnt_d  = '0;
          tcnt_d = tout_i;
          st_d   = no_rsp_i ? ST_GAP : ST_WAIT;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      ST_WAIT: if (ce_i) begin
        if (!cmd_in_i) begin
          rx_shift_o = 1'b1;
          cnt_d      = CNT_ONE;
          st_d       = ST_RX;
        end else if (tcnt_q <= TOUT_ONE) begin
          done_o = 1'b1;
          tmo_o  = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          tcnt_d = tcnt_q - TOUT_ONE;
        end
      end
      ST_RX: if (ce_i) begin
        rx_shift_o = 1'b1;
        if (cnt_q == (long_i ? LONG_LAST : SHORT_LAST)) st_d = ST_EVAL;
        else                                            cnt_d = cnt_q + CNT_ONE;
      end
      ST_EVAL: begin
        if (!long_i && crc_bad) begin
          done_o    = 1'b1;
          crc_err_o = 1'b1;
          st_d      = ST_IDLE;
        end else if (busy_wait_i) begin
          st_d = ST_BUSY;
        end else begin
          done_o = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      ST_GAP: if (ce_i) begin
        if (cnt_q == GAP_LAST) begin
          done_o = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      ST_BUSY: if (ce_i && dat0_i) begin
        done_o     = 1'b1;
        busy_end_o = 1'b1;
        st_d       = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      tcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      tcnt_q <= tcnt_d;
    end
  end

  // R4: the silent pause is entered only for commands flagged as having no response
  assert_gap_only_norsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP) |-> no_rsp_i);

  // R8: busy ends only after a response was taken and with busy wait requested
  assert_busy_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUSY) |-> busy_wait_i);

endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine
  import sdc_pkg::*;
#(
  parameter int TOUT_W   = 32,
  parameter int GAP_CLKS = 8,
  parameter int RSP_WORDS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        card_ce_i,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_addr_i,
  input  logic [31:0] wr_data_i,
  output logic [15:0] cmd_reg_o,
  output logic [31:0] arg_reg_o,
  output logic [10:0] host_status_o,
  output logic [31:0] rsp_w0_o,
  output logic [31:0] rsp_w1_o,
  output logic [31:0] rsp_w2_o,
  output logic [31:0] rsp_w3_o,
  output logic        cmd_out_o,
  output logic        cmd_oe_o,
  input  logic        cmd_in_i,
  input  logic        dat0_i
);

  localparam logic [1:0]  A_CMD  = 2'd0;
  localparam logic [1:0]  A_ARG  = 2'd1;
  localparam logic [1:0]  A_TOUT = 2'd2;
  localparam logic [1:0]  A_STS  = 2'd3;
  localparam logic [10:0] STS_W1C = 11'h450;
  localparam logic [15:0] FAIL_MASK = 16'(1) << B_FAIL;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic [15:0]                cmd_q, cmd_d;
  logic [31:0]                arg_q, arg_d;
  logic [TOUT_W-1:0]          tout_q, tout_d;
  logic [10:0]                sts_q, sts_d;
  logic [RSP_WORDS-1:0][31:0] rsp_q, rsp_d;

  logic                    go, tx_load, tx_shift, rx_shift;
  logic                    done, tmo, crc_err, busy_end;
  logic [HEAD_W-1:0]       tx_head;
  logic [CMD_FRAME_W-1:0]  tx_frame;
  logic [LONG_FRAME_W-1:0] rx_frame;

  assign go       = wr_en_i && (wr_addr_i == A_CMD) && wr_data_i[B_NEW] && !cmd_q[B_NEW];
  assign tx_head  = {1'b0, 1'b1, wr_data_i[5:0], arg_q};
  assign tx_frame = {tx_head, crc7_40(tx_head), 1'b1};

  sdc_tx_shift #(.FRAME_W(CMD_FRAME_W)) u_tx (
    .clk(clk), .rst_n(rst_int_n), .load_i(tx_load), .shift_i(tx_shift),
    .frame_i(tx_frame), .line_o(cmd_out_o)
  );

  sdc_rx_shift #(.FRAME_W(LONG_FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_int_n), .clr_i(tx_load), .shift_i(rx_shift),
    .bit_i(cmd_in_i), .frame_o(rx_frame)
  );

  sdc_cmd_fsm #(.TOUT_W(TOUT_W), .GAP_CLKS(GAP_CLKS)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .ce_i(card_ce_i), .go_i(go),
    .long_i(cmd_q[B_LONG]), .no_rsp_i(cmd_q[B_NORSP]), .busy_wait_i(cmd_q[B_BUSYW]),
    .tout_i(tout_q), .cmd_in_i(cmd_in_i), .dat0_i(dat0_i),
    .rsp_short_i(rx_frame[CMD_FRAME_W-1:0]),
    .tx_load_o(tx_load), .tx_shift_o(tx_shift), .rx_shift_o(rx_shift),
    .cmd_oe_o(cmd_oe_o), .done_o(done), .tmo_o(tmo), .crc_err_o(crc_err),
    .busy_end_o(busy_end)
  );

  always_comb begin
    cmd_d  = cmd_q;
    arg_d  = arg_q;
    tout_d = tout_q;
    sts_d  = sts_q;
    rsp_d  = rsp_q;
    if (wr_en_i) begin
      case (wr_addr_i)
        A_CMD:   if (!cmd_q[B_NEW]) cmd_d = wr_data_i[15:0] & ~FAIL_MASK;
        A_ARG:   arg_d  = wr_data_i;
        A_TOUT:  tout_d = wr_data_i[TOUT_W-1:0];
        A_STS:   sts_d  = sts_q & ~(wr_data_i[10:0] & STS_W1C);
        default: ;
      endcase
    end
    if (done) begin
      cmd_d[B_NEW]  = 1'b0;
      cmd_d[B_FAIL] = tmo | crc_err;
      if (tmo)      sts_d[S_TMO]  = 1'b1;
      if (crc_err)  sts_d[S_CRC]  = 1'b1;
      if (busy_end) sts_d[S_BUSY] = 1'b1;
      if (!tmo && !cmd_q[B_NORSP]) begin
        if (cmd_q[B_LONG]) begin
          for (int w = 0; w < RSP_WORDS; w++) rsp_d[w] = rx_frame[32*w +: 32];
        end else begin
          rsp_d[0] = rx_frame[39:8];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cmd_q  <= '0;
      arg_q  <= '0;
      tout_q <= '1;
      sts_q  <= '0;
      rsp_q  <= '0;
    end else begin
      cmd_q  <= cmd_d;
      arg_q  <= arg_d;
      tout_q <= tout_d;
      sts_q  <= sts_d;
      rsp_q  <= rsp_d;
    end
  end

  assign cmd_reg_o     = cmd_q;
  assign arg_reg_o     = arg_q;
  assign host_status_o = sts_q;
  assign rsp_w0_o      = rsp_q[0];
  assign rsp_w1_o      = rsp_q[1];
  assign rsp_w2_o      = rsp_q[2];
  assign rsp_w3_o      = rsp_q[3];

  // R2: a frame opens with a 0 start bit
  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(cmd_oe_o) |-> !cmd_out_o);

  // R2: the last driven bit is the 1 end bit
  assert_end_bit_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(cmd_oe_o) |-> $past(cmd_out_o));

  // R10: line driven only with an open command
  assert_oe_open_cmd_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmd_oe_o |-> cmd_q[B_NEW]);

  // R3: the completion strobe always closes the command
  assert_done_clears_new_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !cmd_q[B_NEW]);

  // R7: a fail flag at completion always has a recorded cause
  assert_fail_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($fell(cmd_q[B_NEW]) && cmd_q[B_FAIL]) |-> (sts_q[S_TMO] || sts_q[S_CRC]));

  // R8: busy end is raised together with completion
  assert_busy_irq_at_end_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(sts_q[S_BUSY]) |-> $fell(cmd_q[B_NEW]));

endmodule

// File: tb/sim_sdc_cmd_engine.sv
module sim_sdc_cmd_engine;

  logic        clk;
  logic        rst_n;
  logic        ce;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [15:0] cmd_reg_o;
  logic [31:0] arg_reg_o;
  logic [10:0] host_status_o;
  logic [31:0] rsp_w0_o, rsp_w1_o, rsp_w2_o, rsp_w3_o;
  logic        cmd_out_o, cmd_oe_o;
  logic        cmd_in, dat0;

  sdc_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .card_ce_i(ce), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cmd_reg_o(cmd_reg_o), .arg_reg_o(arg_reg_o),
    .host_status_o(host_status_o), .rsp_w0_o(rsp_w0_o), .rsp_w1_o(rsp_w1_o),
    .rsp_w2_o(rsp_w2_o), .rsp_w3_o(rsp_w3_o), .cmd_out_o(cmd_out_o),
    .cmd_oe_o(cmd_oe_o), .cmd_in_i(cmd_in), .dat0_i(dat0)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  logic finished = 1'b0;

  typedef struct packed {
    logic         fail;
    logic         tmo;
    logic         crc;
    logic         busy;
    logic         chk_rsp;
    logic         lng;
    logic [127:0] w;
  } exp_t;

  exp_t exp_q[$];

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc7(input logic [39:0] m);
    logic [6:0] r;
    logic       t;
    r = 7'd0;
    for (int k = 0; k < 40; k++) begin
      t    = m[39-k] ^ r[6];
      r    = {r[5:0], t};
      r[3] = r[3] ^ t;
    end
    return r;
  endfunction

  function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] body,
                                            input logic corrupt);
    logic [39:0] h;
    logic [6:0]  c;
    h = {2'b00, idx, body};
    c = ref_crc7(h) ^ {6'd0, corrupt};
    return {88'd0, h, c, 1'b1};
  endfunction

  task automatic tick();
    @(negedge clk);
    ce = ~ce;
  endtask

  task automatic next_ce();
    do tick(); while (!ce);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (cmd_reg_o[15]) tick();
    tick(); tick();
  endtask

  // card model: collect the 48-bit command frame, check it (R2)
  task automatic capture(input logic [5:0] idx, input logic [31:0] arg);
    logic [47:0] got;
    logic [39:0] h;
    while (!(ce && cmd_oe_o)) tick();
    for (int i = 0; i < 48; i++) begin
      got[47-i] = cmd_out_o;
      if (i < 47) next_ce();
    end
    h = {2'b01, idx, arg};
    chk("R2 command frame", {80'd0, got}, {80'd0, h, ref_crc7(h), 1'b1});
  endtask

  // card model: pause, then send a response frame; optionally pull DAT0 low with the last bit
  task automatic send_rsp(input logic [135:0] bits, input int len, input int delay,
                          input logic hold_busy);
    for (int d = 0; d < delay; d++) next_ce();
    for (int i = 0; i < len; i++) begin
      next_ce();
      cmd_in = bits[len-1-i];
      if (i == len - 1 && hold_busy) dat0 = 1'b0;
    end
    next_ce();
    cmd_in = 1'b1;
  endtask

  // monitor: at each completion pop the expected outcome and compare
  logic prev_new = 1'b0;
  always @(negedge clk) begin
    if (rst_n && prev_new && !cmd_reg_o[15]) begin
      if (exp_q.size() == 0) begin
        chk("R3 unexpected completion", 128'd1, 128'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R3 fail flag", {127'd0, cmd_reg_o[14]}, {127'd0, e.fail});
        chk("R7 timeout status", {127'd0, host_status_o[6]}, {127'd0, e.tmo});
        chk("R5 crc status", {127'd0, host_status_o[4]}, {127'd0, e.crc});
        chk("R8 busy status", {127'd0, host_status_o[10]}, {127'd0, e.busy});
        if (e.chk_rsp && e.lng)
          chk("R6 long response words", {rsp_w3_o, rsp_w2_o, rsp_w1_o, rsp_w0_o}, e.w);
        else if (e.chk_rsp)
          chk("R5 short response word", {96'd0, rsp_w0_o}, {96'd0, e.w[31:0]});
      end
    end
    prev_new = cmd_reg_o[15];
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    exp_t e;
    logic [127:0] lw;
    rst_n = 1'b0; ce = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    cmd_in = 1'b1; dat0 = 1'b1;
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    chk("R1 command word", {112'd0, cmd_reg_o}, 128'd0);
    chk("R1 status", {117'd0, host_status_o}, 128'd0);
    chk("R1 responses", {rsp_w3_o, rsp_w2_o, rsp_w1_o, rsp_w0_o}, 128'd0);
    chk("R1 line idle", {126'd0, cmd_oe_o, cmd_out_o}, 128'd1);

    wr(2'd2, 32'd64);

    // R5 short response, good CRC
    wr(2'd3, 32'h450);
    wr(2'd1, 32'h1234_5678);
    e = '{fail:1'b0, tmo:1'b0, crc:1'b0, busy:1'b0, chk_rsp:1'b1, lng:1'b0,
          w:{96'd0, 32'hCAFE_BABE}};
    exp_q.push_back(e);
    wr(2'd0, 32'h8000 | 32'd17);
    capture(6'd17, 32'h1234_5678);
    send_rsp(mk_short(6'd17, 32'hCAFE_BABE, 1'b0), 48, 2, 1'b0);
    wait_idle();

    // R5 short response, corrupted CRC
    wr(2'd3, 32'h450);
    wr(2'd1, 32'h0000_00A5);
    e = '{fail:1'b1, tmo:1'b0, crc:1'b1, busy:1'b0, chk_rsp:1'b0, lng:1'b0, w:'0};
    exp_q.push_back(e);
    wr(2'd0, 32'h8000 | 32'd13);
    capture(6'd13, 32'h0000_00A5);
    send_rsp(mk_short(6'd13, 32'h0BAD_F00D, 1'b1), 48, 1, 1'b0);
    wait_idle();

    // R6 long response, arbitrary CRC byte not checked
    wr(2'd3, 32'h450);
    wr(2'd1, 32'hFFFF_0000);
    lw = {32'h89AB_CDEF, 32'h0246_8ACE, 32'h1357_9BDF, 32'h0123_4500};
    e = '{fail:1'b0, tmo:1'b0, crc:1'b0, busy:1'b0, chk_rsp:1'b1, lng:1'b1, w:lw};
    exp_q.push_back(e);
    wr(2'd0, 32'h8000 | 32'h0200 | 32'd2);
    capture(6'd2, 32'hFFFF_0000);
    send_rsp({8'h3F, lw}, 136, 3, 1'b0);
    wait_idle();

    // R4 no response: completes on the eighth card clock after the end bit
    wr(2'd3, 32'h450);
    wr(2'd1, 32'd0);
    e = '{fail:1'b0, tmo:1'b0, crc:1'b0, busy:1'b0, chk_rsp:1'b0, lng:1'b0, w:'0};
    exp_q.push_back(e);
    wr(2'd0, 32'h8000 | 32'h0400);
    capture(6'd0, 32'd0);
    repeat (16) tick();
    chk("R4 open after seven card clocks", {127'd0, cmd_reg_o[15]}, 128'd1);
    tick();
    chk("R4 closed on eighth card clock", {127'd0, cmd_reg_o[15]}, 128'd0);
    wait_idle();

    // R7 timeout after five silent card clocks
    wr(2'd3, 32'h450);
    wr(2'd2, 32'd5);
    wr(2'd1, 32'h0000_1111);
    e = '{fail:1'b1, tmo:1'b1, crc:1'b0, busy:1'b0, chk_rsp:1'b0, lng:1'b0, w:'0};
    exp_q.push_back(e);
    wr(2'd0, 32'h8000 | 32'd8);
    capture(6'd8, 32'h0000_1111);
    repeat (10) tick();
    chk("R7 open before fifth silent clock", {127'd0, cmd_reg_o[15]}, 128'd1);
    tick();
    chk("R7 closed on fifth silent clock", {127'd0, cmd_reg_o[15]}, 128'd0);
    wait_idle();

    // R9 write-one-to-clear touches only the written bits
    wr(2'd3, 32'h010);
    chk("R9 timeout bit kept", {117'd0, host_status_o}, {117'd0, 11'h040});
    wr(2'd3, 32'h040);
    chk("R9 timeout bit cleared", {117'd0, host_status_o}, 128'd0);
    wr(2'd2, 32'd64);

    // R8 busy wait, with R3 ignored write while open
    wr(2'd3, 32'h450);
    wr(2'd1, 32'h0000_0007);
    e = '{fail:1'b0, tmo:1'b0, crc:1'b0, busy:1'b1, chk_rsp:1'b1, lng:1'b0,
          w:{96'd0, 32'h0000_0900}};
    exp_q.push_back(e);
    wr(2'd0, 32'h8000 | 32'h0800 | 32'd7);
    capture(6'd7, 32'h0000_0007);
    send_rsp(mk_short(6'd7, 32'h0000_0900, 1'b0), 48, 2, 1'b1);
    wr(2'd0, 32'h8000 | 32'd5);
    chk("R3 write while open ignored", {112'd0, cmd_reg_o}, {112'd0, 16'h8807});
    for (int b = 0; b < 5; b++) next_ce();
    chk("R8 open while DAT0 low", {127'd0, cmd_reg_o[15]}, 128'd1);
    dat0 = 1'b1;
    wait_idle();

    chk("R3 every command completed", {96'd0, 32'(exp_q.size())}, 128'd0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule